// File: doc/BRIEF.md
# Acquisition Event Status and Interrupt Register

This block is the combined status and control register of a data acquisition front end. It sits on a host byte bus at a single address. A read strobe returns a status byte, and a write strobe loads a control byte. The status byte mixes two kinds of bits. Five bits are live conditions from the converter and sample buffer: idle, running, buffer full, buffer near-full and buffer empty. Three bits are sticky events: overrun (data lost), end of scan and buffer level reached.

Each event source delivers a one-cycle pulse, and the block holds it until the host reads the status. A read returns the state from before the clear, and the sticky bits are then cleared. An event that arrives in the same cycle as the read survives the clear, so it shows up in the next read.

The control byte selects the pacer clock, the expansion mode and the trigger mode, source and edge. It also holds two interrupt enables, one for end of scan and one for buffer level. A level interrupt stays asserted while an enabled event is pending.

Top module: `event_status_reg`

## Requirements
- R1: After reset all sticky events, all control bits, `irq` and `host_rdata` are zero.
- R2: A read strobe sampled at a clock edge places the status byte on `host_rdata` after that edge, and it holds until the next read. The bit layout is 7 idle, 6 running, 5 overrun, 4 end of scan, 3 buffer level, 2 full, 1 near-full, 0 empty.
- R3: A one-cycle pulse on an event input sets its sticky bit at the next edge, and the bit stays set until a read clears it.
- R4: A read returns the sticky bits as they stood before the read, and clears all three at the same edge.
- R5: An event pulse that coincides with a read is not in that read's value but remains set afterwards.
- R6: A write strobe loads `host_wdata` into control. The pacer select is bits 7:6 and the expansion enable is bit 5. Bit 4 enables the end-of-scan interrupt and bit 3 enables the buffer-level interrupt. Trigger continuous is bit 2, trigger external is bit 1 and trigger falling edge is bit 0.
- R7: `irq` is high exactly when one of these holds: end of scan is pending with its enable set, buffer level is pending with its enable set, or overrun is pending with either enable set.
- R8: Writing zero to control drops `irq` after that edge, while pending events stay readable.
- R9: The live bits in a read reflect the inputs in the cycle of the read strobe and are never held.
- R10: A write does not alter the sticky events, and a read does not alter the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | Status read strobe, one cycle per read |
| host_wr | input | 1 | Control write strobe |
| host_wdata | input | 8 | Control byte to load |
| host_rdata | output | 8 | Last status byte read |
| conv_idle | input | 1 | Live: converter idle |
| conv_running | input | 1 | Live: acquisition running |
| buf_full | input | 1 | Live: sample buffer full |
| buf_near_full | input | 1 | Live: sample buffer near full |
| buf_empty | input | 1 | Live: sample buffer empty |
| ev_overrun | input | 1 | Event pulse: sample lost |
| ev_scan_end | input | 1 | Event pulse: scan completed |
| ev_buf_level | input | 1 | Event pulse: buffer level reached |
| irq | output | 1 | Level interrupt request |
| pacer_sel | output | 2 | Pacer clock select |
| expand_en | output | 1 | Expansion mode enable |
| trig_continuous | output | 1 | Trigger mode continuous |
| trig_external | output | 1 | Trigger source external |
| trig_falling | output | 1 | Trigger on falling edge |

## Verification
The hardest case to reach is an event pulse in exactly the cycle in which a read strobe is sampled. In that cycle the clear and the set collide, and the returned byte must still show the bit as clear. A directed sequence raises the strobe and the pulse in the same drive slot. A random phase also drives strobes and pulses densely enough that such collisions recur many times. In both phases a behavioural model in the bench predicts the status byte, the control outputs and the interrupt on every cycle, so any wrong priority between clear and set shows up.

// File: rtl/esr_pkg.sv
package esr_pkg;
   localparam int NUM_EVT = 3;
   // sticky vector order, also the order of status bits 5:3
   localparam int EV_LOST = 2;
   localparam int EV_SCAN = 1;
   localparam int EV_LVL  = 0;

   typedef struct packed {
      logic [1:0] pacer;
      logic       expand;
      logic       scan_ie;
      logic       lvl_ie;
      logic       trig_cont;
      logic       trig_ext;
      logic       trig_fall;
   } ctrl_t;
endpackage

// File: rtl/esr_event_bank.sv
module esr_event_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] pulse,
   output logic [N-1:0] pend
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend[i] <= 1'b0;
         else if (pulse[i])
            pend[i] <= 1'b1;
         else if (clr)
            pend[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/esr_ctrl_reg.sv
module esr_ctrl_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (wr)
         q <= wdata;
   end
endmodule

// File: rtl/esr_irq_merge.sv
module esr_irq_merge
   import esr_pkg::*;
(
   input  logic [NUM_EVT-1:0] pend,
   input  logic               scan_ie,
   input  logic               lvl_ie,
   output logic               irq
);
   logic [NUM_EVT-1:0] mask;
   always_comb begin
      mask          = '0;
      mask[EV_SCAN] = scan_ie;
      mask[EV_LVL]  = lvl_ie;
      mask[EV_LOST] = scan_ie | lvl_ie;
      irq           = |(pend & mask);
   end
endmodule

// File: rtl/event_status_reg.sv
module event_status_reg
   import esr_pkg::*;
#(
   parameter int BUS_W       = 8,
   parameter bit READBACK_FF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_rd,
   input  logic             host_wr,
   input  logic [BUS_W-1:0] host_wdata,
   output logic [BUS_W-1:0] host_rdata,
   input  logic             conv_idle,
   input  logic             conv_running,
   input  logic             buf_full,
   input  logic             buf_near_full,
   input  logic             buf_empty,
   input  logic             ev_overrun,
   input  logic             ev_scan_end,
   input  logic             ev_buf_level,
   output logic             irq,
   output logic [1:0]       pacer_sel,
   output logic             expand_en,
   output logic             trig_continuous,
   output logic             trig_external,
   output logic             trig_falling
);
   localparam int CTRL_W = $bits(ctrl_t);

   if (BUS_W != CTRL_W) begin : g_bad_width
      $error("event_status_reg: BUS_W must equal control width");
   end

   logic [NUM_EVT-1:0] ev_vec;
   logic [NUM_EVT-1:0] sticky_q;
   logic [BUS_W-1:0]   ctrl_raw;
   ctrl_t              ctrl;
   logic [BUS_W-1:0]   status_now;

   assign ev_vec[EV_LOST] = ev_overrun;
   assign ev_vec[EV_SCAN] = ev_scan_end;
   assign ev_vec[EV_LVL]  = ev_buf_level;

   esr_event_bank #(.N(NUM_EVT)) u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (host_rd),
      .pulse (ev_vec),
      .pend  (sticky_q)
   );

   esr_ctrl_reg #(.W(BUS_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (host_wr),
      .wdata (host_wdata),
      .q     (ctrl_raw)
   );

   assign ctrl = ctrl_t'(ctrl_raw);

   esr_irq_merge u_irq (
      .pend    (sticky_q),
      .scan_ie (ctrl.scan_ie),
      .lvl_ie  (ctrl.lvl_ie),
      .irq     (irq)
   );

   assign status_now = {conv_idle, conv_running, sticky_q,
                        buf_full, buf_near_full, buf_empty};

   if (READBACK_FF) begin : g_rd_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            host_rdata <= '0;
         else if (host_rd)
            host_rdata <= status_now;
      end
   end else begin : g_rd_comb
      assign host_rdata = status_now;
   end

   assign pacer_sel       = ctrl.pacer;
   assign expand_en       = ctrl.expand;
   assign trig_continuous = ctrl.trig_cont;
   assign trig_external   = ctrl.trig_ext;
   assign trig_falling    = ctrl.trig_fall;
endmodule

// File: rtl/event_status_reg_chk.sv
module event_status_reg_chk #(
   parameter bit RB_FF = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rd,
   input logic       wr,
   input logic [7:0] wdata,
   input logic [7:0] rdata,
   input logic [2:0] ev,
   input logic [2:0] sticky,
   input logic       irq
);
   a_r1_reset: assert property (@(posedge clk) !rst_n |=> (sticky == 3'b000 && !irq));

   a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != 3'b000) |=> ((sticky & $past(ev)) == $past(ev)));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> ((sticky & $past(sticky)) == $past(sticky)));

   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && ev == 3'b000) |=> (sticky == 3'b000));

   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky == 3'b000) |-> !irq);

   a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata == 8'h00) |=> !irq);

   if (RB_FF) begin : g_rb
      a_r2_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
         rd |=> (rdata[5:3] == $past(sticky)));
   end
endmodule

bind event_status_reg event_status_reg_chk #(.RB_FF(READBACK_FF)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .rd     (host_rd),
   .wr     (host_wr),
   .wdata  (host_wdata),
   .rdata  (host_rdata),
   .ev     ({ev_overrun, ev_scan_end, ev_buf_level}),
   .sticky (sticky_q),
   .irq    (irq)
);

// File: tb/event_status_reg_test.sv
module event_status_reg_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_rd = 0, host_wr = 0;
   logic [7:0] host_wdata = 0;
   logic [7:0] host_rdata;
   logic       conv_idle = 0, conv_running = 0, buf_full = 0, buf_near_full = 0, buf_empty = 0;
   logic       ev_overrun = 0, ev_scan_end = 0, ev_buf_level = 0;
   logic       irq, expand_en, trig_continuous, trig_external, trig_falling;
   logic [1:0] pacer_sel;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   event_status_reg uut (
      .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .conv_idle(conv_idle), .conv_running(conv_running), .buf_full(buf_full),
      .buf_near_full(buf_near_full), .buf_empty(buf_empty),
      .ev_overrun(ev_overrun), .ev_scan_end(ev_scan_end), .ev_buf_level(ev_buf_level),
      .irq(irq), .pacer_sel(pacer_sel), .expand_en(expand_en),
      .trig_continuous(trig_continuous), .trig_external(trig_external),
      .trig_falling(trig_falling)
   );

   // behavioural reference model
   bit m_lost, m_scan, m_lvl;
   int m_ctrl;
   int m_rdata;

   function automatic bit model_irq();
      bit sie, lie;
      sie = m_ctrl[4];
      lie = m_ctrl[3];
      return (m_scan && sie) || (m_lvl && lie) || (m_lost && (sie || lie));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lost = 0; m_scan = 0; m_lvl = 0; m_ctrl = 0; m_rdata = 0;
      end else begin
         if (host_rd)
            m_rdata = {conv_idle, conv_running, m_lost, m_scan, m_lvl,
                       buf_full, buf_near_full, buf_empty};
         m_lost = ev_overrun   || (m_lost && !host_rd);
         m_scan = ev_scan_end  || (m_scan && !host_rd);
         m_lvl  = ev_buf_level || (m_lvl && !host_rd);
         if (host_wr) m_ctrl = host_wdata;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 model rdata", host_rdata, m_rdata & 8'hff);
         check("R7 model irq", irq, model_irq());
         check("R6 model ctrl",
               {pacer_sel, expand_en, trig_continuous, trig_external, trig_falling},
               {m_ctrl[7:5], m_ctrl[2:0]});
      end
   end

   task automatic do_read(output logic [7:0] v);
      @(negedge clk) host_rd = 1;
      @(negedge clk) host_rd = 0;
      v = host_rdata;
   endtask

   task automatic do_write(input logic [7:0] d);
      @(negedge clk) begin host_wr = 1; host_wdata = d; end
      @(negedge clk) host_wr = 0;
   endtask

   task automatic pulse(input bit lost, input bit scan, input bit lvl);
      @(negedge clk) begin ev_overrun = lost; ev_scan_end = scan; ev_buf_level = lvl; end
      @(negedge clk) begin ev_overrun = 0; ev_scan_end = 0; ev_buf_level = 0; end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      check("R1 rdata", host_rdata, 0);
      check("R1 irq", irq, 0);
      check("R1 ctrl", {pacer_sel, expand_en, trig_continuous, trig_external, trig_falling}, 0);

      // R2 / R9 live bits
      @(negedge clk) begin conv_idle = 1; buf_empty = 1; end
      do_read(v);
      check("R2 idle+empty", v, 8'h81);
      @(negedge clk) begin conv_idle = 0; buf_empty = 0; conv_running = 1; buf_full = 1; buf_near_full = 1; end
      do_read(v);
      check("R9 live follows inputs", v, 8'h46);
      @(negedge clk) begin conv_running = 0; buf_full = 0; buf_near_full = 0; end
      do_read(v);
      check("R9 live not held", v, 8'h00);

      // R3 / R4
      pulse(0, 1, 0);
      repeat (3) @(negedge clk);
      do_read(v);
      check("R3 scan end sticky", v, 8'h10);
      do_read(v);
      check("R4 cleared by read", v, 8'h00);
      pulse(1, 1, 1);
      do_read(v);
      check("R3 all events", v, 8'h38);

      // R5 coincident event
      @(negedge clk) begin host_rd = 1; ev_overrun = 1; end
      @(negedge clk) begin host_rd = 0; ev_overrun = 0; end
      check("R5 coincident not in read", host_rdata, 8'h00);
      do_read(v);
      check("R5 coincident kept", v, 8'h20);

      // R7 interrupt enables
      do_write(8'h10);
      pulse(0, 1, 0);
      check("R7 scan irq", irq, 1);
      do_read(v);
      @(negedge clk);
      check("R7 irq clears on read", irq, 0);
      pulse(0, 0, 1);
      check("R7 level masked", irq, 0);
      do_write(8'h08);
      check("R7 level enabled", irq, 1);
      do_read(v);
      pulse(1, 0, 0);
      check("R7 overrun via level enable", irq, 1);

      // R8 / R10 write zero
      do_write(8'h00);
      check("R8 irq off after zero write", irq, 0);
      do_read(v);
      check("R10 events survive write", v, 8'h20);

      // R6 / R10 control fields
      do_write(8'he7);
      check("R6 pacer", pacer_sel, 2'b11);
      check("R6 flags", {expand_en, trig_continuous, trig_external, trig_falling}, 4'b1111);
      do_read(v);
      check("R10 read keeps ctrl", {pacer_sel, expand_en, trig_falling}, 4'b1111);
      do_write(8'h5a);
      check("R6 pattern", {pacer_sel, expand_en, trig_continuous, trig_external, trig_falling}, 6'b010010);

      // random phase compared with the model each cycle
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         host_rd       = ($urandom_range(0, 3) == 0);
         host_wr       = ($urandom_range(0, 7) == 0);
         host_wdata    = 8'($urandom);
         {conv_idle, conv_running, buf_full, buf_near_full, buf_empty} = 5'($urandom);
         ev_overrun    = ($urandom_range(0, 5) == 0);
         ev_scan_end   = ($urandom_range(0, 4) == 0);
         ev_buf_level  = ($urandom_range(0, 4) == 0);
      end
      @(negedge clk) begin
         host_rd = 0; host_wr = 0; ev_overrun = 0; ev_scan_end = 0; ev_buf_level = 0;
      end
      repeat (2) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule